// File: doc/BRIEF.md
# Ordered-List Adaptive Prefix Encoder

This block is the second stage of a dictionary compressor. It takes fixed-width 9-bit symbols, one at a time, and emits a variable-length prefix-free code for each. It keeps every symbol of the 368-symbol alphabet in a list of registers and searches the whole list in parallel for each arriving symbol. The position found is the value that gets coded. Small positions receive short codes. After each lookup the symbol is moved closer to the head of the list, so the symbols seen most often collect at small positions.

The code is chosen by comparing the position against a table of range bases, all at once. The range selects a code length and a first code. The code equals the first code plus the distance of the position from the range base.

Promotion follows one of two rules. The list has exchange windows, and each window keeps its own pointer. A symbol found deeper in a window than that window's pointer trades places with the entry at the pointer. The pointer then advances, and falls back to half its span when it reaches a limit. Any other symbol trades places with its upper neighbour. A separate packer outside this block turns the code and length pairs into a byte stream.

Top module: `olh_huff_encoder`

## Requirements
- R1: After reset, list position i holds symbol i, each window pointer sits at the first position of its window, `out_valid` is 0 and `in_ready` is 1.
- R2: The position that gets coded is the symbol's place in the list before that symbol's own promotion. The range is the last one whose base is at or below the position, with bases 0, 1, 9, 18, 31, 101, 154, 171 and 186. The code lengths of those ranges are 4, 5, 6, 7, 8, 10, 11, 11 and 13 bits.
- R3: The code equals the position minus the range base plus the range's first code, and the first codes are 15, 22, 35, 57, 44, 39, 61, 46 and 0. The code sits right-aligned in `out_code`, its most significant code bit is bit `out_len-1`, and all higher bits are 0. For example, position 38 gives length 8 and code 0b00110011.
- R4: The default windows cover positions 18..100 and 101..367. A symbol found inside a window, at a position strictly greater than that window's pointer, swaps with the entry at the pointer, and the pointer then advances by one.
- R5: The pointer limit is 6. When a pointer's offset from its window start would reach 6 on advancing, the offset becomes 3 instead.
- R6: A symbol at a nonzero position that no window claims swaps with the entry one position above it. A symbol at position 0 leaves the list unchanged.
- R7: A symbol is accepted on a clock edge where `in_valid` and `in_ready` are both 1. The code appears with `out_valid` after that edge. `in_ready` is 0 for the following cycle, while the swap is made, so at most one symbol is taken every two cycles.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_code` and `out_len` hold steady and `in_ready` stays 0.
- R9: The symbol at position 0 is coded as the 4-bit value 0b1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Symbol offered |
| in_ready | output | 1 | Block can take a symbol this cycle |
| in_sym | input | 9 | Symbol value, 0..367 |
| out_valid | output | 1 | Code available |
| out_ready | input | 1 | Consumer takes the code this cycle |
| out_code | output | 13 | Code bits, right-aligned |
| out_len | output | 4 | Number of valid code bits |

## Verification
The assertions assume that every offered symbol lies below 368. When that holds, exactly one list entry matches, and the lookup check depends on this. They also assume that the default windows do not overlap and that each window is wider than the pointer limit. The stimulus draws every symbol from the alphabet, mixing a small hot set, which drives repeated window promotions and pointer fallbacks, with uniform picks across all positions. It holds `out_ready` low only while a code is waiting, which matches the handshake the hold check expects.

// File: rtl/olh_pkg.sv
package olh_pkg;

  typedef enum logic {
    PH_LOOK = 1'b0,
    PH_SWAP = 1'b1
  } phase_e;

  localparam int unsigned NRANGE = 9;

  typedef int unsigned range_tab_t [NRANGE];

  // lower bound of each position range, ascending
  localparam range_tab_t DEF_BASE  = '{0, 1, 9, 18, 31, 101, 154, 171, 186};
  // code length in bits for each range
  localparam range_tab_t DEF_LEN   = '{4, 5, 6, 7, 8, 10, 11, 11, 13};
  // code value given to the first position of each range
  localparam range_tab_t DEF_FIRST = '{15, 22, 35, 57, 44, 39, 61, 46, 0};

endpackage

// File: rtl/olh_cam_search.sv
module olh_cam_search #(
  parameter int unsigned NSYM = 368,
  parameter int unsigned SW   = 9,
  localparam int unsigned IW  = $clog2(NSYM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] list_i [NSYM],
  input  logic [SW-1:0] key_i,
  input  logic          check_i,
  output logic [IW-1:0] idx_o
);

  logic [NSYM-1:0] hit;

  // one comparator per list slot
  for (genvar g = 0; g < NSYM; g++) begin : g_cmp
    assign hit[g] = (list_i[g] == key_i);
  end

  // the list is a permutation, so an OR of matching positions is the index
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSYM; i++) begin
      if (hit[i]) idx_o = idx_o | IW'(i);
    end
  end

  // a lookup on an accepted symbol finds exactly one slot
  assert_single_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_i |-> ($countones(hit) == 1));

endmodule

// File: rtl/olh_canon_enc.sv
module olh_canon_enc
  import olh_pkg::*;
#(
  parameter int unsigned IW     = 9,
  parameter int unsigned MAXLEN = 13,
  parameter range_tab_t  BASE   = DEF_BASE,
  parameter range_tab_t  LEN    = DEF_LEN,
  parameter range_tab_t  FIRST  = DEF_FIRST,
  localparam int unsigned LW    = $clog2(MAXLEN + 1)
) (
  input  logic [IW-1:0]     idx_i,
  output logic [MAXLEN-1:0] code_o,
  output logic [LW-1:0]     len_o
);

  // last range whose base does not exceed the position
  function automatic int pick_range(input logic [IW-1:0] ix);
    int r;
    r = 0;
    for (int k = 0; k < int'(NRANGE); k++) begin
      if (int'(ix) >= int'(BASE[k])) r = k;
    end
    return r;
  endfunction

  function automatic int code_value(input logic [IW-1:0] ix, input int r);
    return int'(ix) - int'(BASE[r]) + int'(FIRST[r]);
  endfunction

  int sel;

  always_comb begin
    sel    = pick_range(idx_i);
    code_o = MAXLEN'(code_value(idx_i, sel));
    len_o  = LW'(LEN[sel]);
  end

endmodule

// File: rtl/olh_block_ctl.sv
module olh_block_ctl #(
  parameter int unsigned NSYM      = 368,
  parameter int unsigned NBLK      = 2,
  parameter int unsigned BLK_LO [NBLK] = '{18, 101},
  parameter int unsigned BLK_HI [NBLK] = '{100, 367},
  parameter int unsigned PTR_LIMIT = 6,
  localparam int unsigned IW       = $clog2(NSYM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic          step_i,
  output logic [IW-1:0] partner_o,
  output logic          move_o
);

  localparam int unsigned FALLBACK = PTR_LIMIT / 2;

  logic [IW-1:0]   ptr_w [NBLK];
  logic [NBLK-1:0] blk_hit;

  // choose the swap partner: a window pointer if one claims the position,
  // otherwise the upper neighbour
  always_comb begin
    partner_o = idx_i - IW'(1);
    move_o    = (idx_i != '0);
    blk_hit   = '0;
    for (int b = 0; b < int'(NBLK); b++) begin
      if ((int'(idx_i) >= int'(BLK_LO[b])) && (int'(idx_i) <= int'(BLK_HI[b]))
          && (idx_i > ptr_w[b])) begin
        blk_hit[b] = 1'b1;
        partner_o  = ptr_w[b];
        move_o     = 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_win
    localparam logic [IW-1:0] LO = IW'(BLK_LO[b]);
    logic [IW-1:0] p_q;
    logic [IW-1:0] off;

    assign off      = p_q - LO;
    assign ptr_w[b] = p_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_q <= LO;
      end else if (step_i && blk_hit[b]) begin
        if (int'(off) + 1 >= int'(PTR_LIMIT)) p_q <= LO + IW'(FALLBACK);
        else                                  p_q <= p_q + IW'(1);
      end
    end

    assert_ptr_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (p_q >= LO) && (int'(p_q - LO) < int'(PTR_LIMIT)));

    assert_ptr_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && blk_hit[b]) |=> (p_q != $past(p_q)));
  end

  // promotion never moves a symbol toward the tail
  assert_swap_upward_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && move_o) |-> (partner_o < idx_i));

endmodule

// File: rtl/olh_huff_encoder.sv
module olh_huff_encoder
  import olh_pkg::*;
#(
  parameter int unsigned NSYM      = 368,
  parameter int unsigned SW        = 9,
  parameter int unsigned MAXLEN    = 13,
  parameter range_tab_t  RANGE_BASE  = DEF_BASE,
  parameter range_tab_t  RANGE_LEN   = DEF_LEN,
  parameter range_tab_t  RANGE_FIRST = DEF_FIRST,
  parameter int unsigned NBLK      = 2,
  parameter int unsigned BLK_LO [NBLK] = '{18, 101},
  parameter int unsigned BLK_HI [NBLK] = '{100, 367},
  parameter int unsigned PTR_LIMIT = 6,
  localparam int unsigned IW       = $clog2(NSYM),
  localparam int unsigned LW       = $clog2(MAXLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SW-1:0]     in_sym,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MAXLEN-1:0] out_code,
  output logic [LW-1:0]     out_len
);

  logic [SW-1:0]     list_q [NSYM];
  phase_e            phase_q;
  logic [IW-1:0]     idx_q;
  logic [SW-1:0]     sym_q;
  logic [IW-1:0]     idx_d;
  logic [MAXLEN-1:0] code_d;
  logic [LW-1:0]     len_d;
  logic [IW-1:0]     partner;
  logic              move;
  logic              accept;
  logic              swap_step;

  assign in_ready  = (phase_q == PH_LOOK) && (!out_valid || out_ready);
  assign accept    = in_valid && in_ready;
  assign swap_step = (phase_q == PH_SWAP);

  olh_cam_search #(.NSYM(NSYM), .SW(SW)) u_search (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .list_i  (list_q),
    .key_i   (in_sym),
    .check_i (accept),
    .idx_o   (idx_d)
  );

  olh_canon_enc #(
    .IW(IW), .MAXLEN(MAXLEN),
    .BASE(RANGE_BASE), .LEN(RANGE_LEN), .FIRST(RANGE_FIRST)
  ) u_enc (
    .idx_i  (idx_d),
    .code_o (code_d),
    .len_o  (len_d)
  );

  olh_block_ctl #(
    .NSYM(NSYM), .NBLK(NBLK), .BLK_LO(BLK_LO), .BLK_HI(BLK_HI),
    .PTR_LIMIT(PTR_LIMIT)
  ) u_blk (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .idx_i     (idx_q),
    .step_i    (swap_step),
    .partner_o (partner),
    .move_o    (move)
  );

  // list storage: identity at reset, one two-entry exchange per symbol
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NSYM); i++) list_q[i] <= SW'(i);
    end else if (swap_step && move) begin
      list_q[idx_q]   <= list_q[partner];
      list_q[partner] <= sym_q;
    end
  end

  // look / swap sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOOK;
      idx_q   <= '0;
      sym_q   <= '0;
    end else if (accept) begin
      phase_q <= PH_SWAP;
      idx_q   <= idx_d;
      sym_q   <= in_sym;
    end else begin
      phase_q <= PH_LOOK;
    end
  end

  // output holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_len   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_code  <= code_d;
      out_len   <= len_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_sym_in_alphabet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(in_sym) < int'(NSYM)));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && !in_ready));

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_len)));

  assert_code_fits_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_code >> out_len) == '0));

endmodule

// File: tb/test_olh_huff_encoder.sv
module test_olh_huff_encoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_sym = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [12:0] out_code;
  logic [3:0]  out_len;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // 20 time units per period: 50 MHz with 1 ns units
  always #10 clk = ~clk;

  olh_huff_encoder i_olh_huff_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sym    (in_sym),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_len   (out_len)
  );

  // behavioural reference: plain list of symbols plus two window pointers
  int lst [368];
  int wptr [2];
  int wlo [2] = '{18, 101};
  int whi [2] = '{100, 367};

  function automatic int ref_find(input int s);
    for (int i = 0; i < 368; i++) if (lst[i] == s) return i;
    return -1;
  endfunction

  // code table restated as position bands
  task automatic ref_code(input int p, output int c, output int l);
    if      (p < 1)   begin l = 4;  c = 15; end
    else if (p < 9)   begin l = 5;  c = 22 + (p - 1);   end
    else if (p < 18)  begin l = 6;  c = 35 + (p - 9);   end
    else if (p < 31)  begin l = 7;  c = 57 + (p - 18);  end
    else if (p < 101) begin l = 8;  c = 44 + (p - 31);  end
    else if (p < 154) begin l = 10; c = 39 + (p - 101); end
    else if (p < 171) begin l = 11; c = 61 + (p - 154); end
    else if (p < 186) begin l = 11; c = 46 + (p - 171); end
    else              begin l = 13; c = p - 186;        end
  endtask

  task automatic ref_promote(input int p);
    int t, w, q;
    w = -1;
    for (int b = 0; b < 2; b++)
      if (p >= wlo[b] && p <= whi[b] && p > wptr[b]) w = b;
    if (w >= 0) begin
      q = wptr[w];
      t = lst[q]; lst[q] = lst[p]; lst[p] = t;
      wptr[w] = wptr[w] + 1;
      if (wptr[w] - wlo[w] >= 6) wptr[w] = wlo[w] + 3;
    end else if (p > 0) begin
      t = lst[p - 1]; lst[p - 1] = lst[p]; lst[p] = t;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // offer one symbol at a falling edge, optionally stall the output
  task automatic send(input int sym, input int stall, input string req);
    int p, ec, el;
    p = ref_find(sym);
    ref_code(p, ec, el);
    ref_promote(p);
    in_valid  = 1'b1;
    in_sym    = 9'(sym);
    out_ready = (stall == 0);
    chk(in_ready == 1'b1, "R7", "ready before offer", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R7", "valid after accept", int'(out_valid), 1);
    chk(int'(out_code) == ec, req, "code", int'(out_code), ec);
    chk(int'(out_len) == el, req, "length", int'(out_len), el);
    chk(in_ready == 1'b0, "R7", "ready during swap", int'(in_ready), 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && int'(out_code) == ec && int'(out_len) == el,
          "R8", "held code", int'(out_code), ec);
      chk(in_ready == 1'b0, "R8", "ready while stalled", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "valid after take", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rs;
    int sym;
    for (int i = 0; i < 368; i++) lst[i] = i;
    wptr[0] = 18;
    wptr[1] = 101;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

    // R9 head symbol, R6 head stays put
    send(0, 0, "R9");
    send(0, 0, "R6");

    // R3 worked example: position 38
    chk(ref_find(38) == 38, "R1", "identity order", ref_find(38), 38);
    send(38, 0, "R3");
    // R4 symbol 38 now sits at the window start
    send(38, 0, "R4");
    // R6 neighbour swap below the pointer
    send(17, 0, "R6");
    send(5, 0, "R6");

    // R5: repeated window promotions until the pointer falls back
    for (int k = 50; k < 56; k++) send(k, 0, "R5");
    send(90, 0, "R5");
    send(90, 0, "R5");

    // window two and the long code ranges
    send(300, 0, "R4");
    send(300, 0, "R4");
    send(160, 0, "R2");
    send(175, 0, "R2");
    send(367, 0, "R2");

    // R8 stalled outputs
    send(44, 3, "R8");
    send(200, 1, "R8");

    // mixed stream: hot set and uniform picks
    rs = 32'h1bad_5eed;
    for (int n = 0; n < 400; n++) begin
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      sym = rs[4] ? int'(rs[15:8] % 24) + 40 : int'(rs[31:16] % 368);
      send(sym, (n % 37 == 0) ? 2 : 0, "R2");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule